// File: doc/BRIEF.md
# Microprogram Sequencer with Embedded Next-Address Field

This block steps through a constant microprogram that is stored inside it. Each microword has three parts: a wide control field, a base address for the following step, and a two-bit branch selector. The control field goes straight to the datapath with no decoding in between. The block has no program counter and no incrementer. The next microaddress is always the base address from the current word. A branch is taken by ORing selected condition inputs into the low bits of that base address. The microprogram author places branch targets so that the low bits of the base address which receive the OR are zero. The sequencer does not check this rule.

The current microaddress is held in a register that updates on every rising clock edge. The store is read combinationally from that register, so the control outputs change in the same clock cycle as the address. A synchronous reset returns the sequencer to word 0.

Top module: `usq_top`

## Requirements
- R1: While `rst` is high at a rising edge, the microaddress becomes 0. From that edge until the first edge with `rst` low, `ctrlOut` shows the control field of word 0.
- R2: `ctrlOut` is the control field of the word at the current microaddress. The word at address a has control field {a XOR 6'h2A, 4'h5, a}, listed from MSB to LSB, and it is visible in the same cycle the address is loaded.
- R3: When the branch selector of the current word is 2'b00, the next address is the base next-address field exactly. Both condition inputs are ignored.
- R4: When the selector is 2'b01, `condIn[0]` is ORed into bit 0 of the base address. `condIn[1]` is ignored.
- R5: When the selector is 2'b10, `condIn[1]` is ORed into bit 0 of the base address. `condIn[0]` is ignored.
- R6: When the selector is 2'b11, `condIn[1]` is ORed into bit 1 and `condIn[0]` is ORed into bit 0 of the base address.
- R7: The address sequence follows only the next-address fields; there is no step of +1. The stored program holds these (address → base, selector) pairs: 0→1/00, 1→4/01, 2→3/00, 3→0/00, 4→8/10, 5→8/00, 8→12/11, 9→0/00, 12→0/00, 13→0/00, 14→63/00, 15→62/00, 62→2/00, 63→0/00. Every other address → 0/00.
- R8: If reset is asserted in the middle of a run, it overrides any pending branch at the next edge. Reset held over several edges keeps the address at 0 whatever the conditions are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to microaddress 0 |
| condIn | input | 2 | Branch condition inputs; bit 0 and bit 1 are ORed into the next address according to the selector |
| ctrlOut | output | 16 | Control field of the current microword |

## Verification
The bench builds the block with its default widths: a 6-bit microaddress, which gives 64 words, and a 16-bit control field. Because the control field carries the address in its low bits, the bench can read every step of the walk at the output port. This lets it reach the extremes of the address space, the jump to word 63 and the jump from word 62 back down to 2, as well as all four selector codes, each with condition patterns that must be ignored and patterns that must take effect. Resets at start-up and in the middle of a run both check that a pending branch is overridden.

// File: rtl/usq_pkg.sv
package usq_pkg;

  localparam int ADDR_W = 6;
  localparam int CTRL_W = 16;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_C0   = 2'b01,
    BR_C1   = 2'b10,
    BR_BOTH = 2'b11
  } brSel_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] next;
    brSel_e            brSel;
  } uWord_t;

  // strobes from the selector decode to the address datapath
  typedef struct packed {
    logic c0ToBit0;
    logic c1ToBit0;
    logic c1ToBit1;
  } brStrobe_t;

  function automatic uWord_t romWord(input logic [ADDR_W-1:0] a);
    uWord_t w;
    w.ctrl  = {a ^ 6'h2A, 4'h5, a};
    w.next  = '0;
    w.brSel = BR_NONE;
    case (a)
      6'd0:  w.next = 6'd1;
      6'd1:  begin w.next = 6'd4;  w.brSel = BR_C0;   end
      6'd2:  w.next = 6'd3;
      6'd4:  begin w.next = 6'd8;  w.brSel = BR_C1;   end
      6'd5:  w.next = 6'd8;
      6'd8:  begin w.next = 6'd12; w.brSel = BR_BOTH; end
      6'd14: w.next = 6'd63;
      6'd15: w.next = 6'd62;
      6'd62: w.next = 6'd2;
      default: w.next = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/usq_store.sv
module usq_store
  import usq_pkg::*;
(
  input  logic [ADDR_W-1:0] uAddr,
  output uWord_t            curWord
);

  uWord_t romArr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign romArr[i] = romWord(ADDR_W'(i));
  end

  assign curWord = romArr[uAddr];

endmodule

// File: rtl/usq_control.sv
module usq_control
  import usq_pkg::*;
(
  input  brSel_e    brSel,
  output brStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (brSel)
      BR_NONE: ;
      BR_C0:   strobes.c0ToBit0 = 1'b1;
      BR_C1:   strobes.c1ToBit0 = 1'b1;
      BR_BOTH: begin
        strobes.c0ToBit0 = 1'b1;
        strobes.c1ToBit1 = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/usq_datapath.sv
module usq_datapath
  import usq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] baseNext,
  input  brStrobe_t         strobes,
  input  logic [1:0]        condIn,
  output logic [ADDR_W-1:0] uAddr
);

  logic [ADDR_W-1:0] orMask;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    orMask    = '0;
    orMask[0] = (strobes.c0ToBit0 & condIn[0]) | (strobes.c1ToBit0 & condIn[1]);
    orMask[1] = strobes.c1ToBit1 & condIn[1];
    nextAddr  = baseNext | orMask;
  end

  always_ff @(posedge clk) begin
    if (rst) uAddr <= '0;
    else     uAddr <= nextAddr;
  end

endmodule

// File: rtl/usq_top.sv
module usq_top
  import usq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        condIn,
  output logic [CTRL_W-1:0] ctrlOut
);

  logic [ADDR_W-1:0] uAddr;
  uWord_t            curWord;
  brStrobe_t         strobes;

  usq_store u_store (
    .uAddr   (uAddr),
    .curWord (curWord)
  );

  usq_control u_ctrl (
    .brSel   (curWord.brSel),
    .strobes (strobes)
  );

  usq_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .baseNext (curWord.next),
    .strobes  (strobes),
    .condIn   (condIn),
    .uAddr    (uAddr)
  );

  assign ctrlOut = curWord.ctrl;

endmodule

// File: rtl/usq_checker.sv
module usq_checker
  import usq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        condIn,
  input logic [ADDR_W-1:0] uAddr,
  input uWord_t            curWord
);

  // R1 / R8: reset edge always lands on word 0
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> uAddr == '0);

  a_r3_plain_next: assert property (@(posedge clk) disable iff (rst)
    (curWord.brSel == BR_NONE) |=> uAddr == $past(curWord.next));

  a_r4_cond0_bit0: assert property (@(posedge clk) disable iff (rst)
    (curWord.brSel == BR_C0) |=>
      uAddr == ($past(curWord.next) | ADDR_W'($past(condIn[0]))));

  a_r5_cond1_bit0: assert property (@(posedge clk) disable iff (rst)
    (curWord.brSel == BR_C1) |=>
      uAddr == ($past(curWord.next) | ADDR_W'($past(condIn[1]))));

  a_r6_both_bits: assert property (@(posedge clk) disable iff (rst)
    (curWord.brSel == BR_BOTH) |=>
      uAddr == ($past(curWord.next) | ADDR_W'($past(condIn))));

endmodule

bind usq_top usq_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .condIn  (condIn),
  .uAddr   (uAddr),
  .curWord (curWord)
);

// File: tb/sim_usq_top.sv
module sim_usq_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;
  // {condIn[1:0], expected address after the edge}
  localparam logic [7:0] VEC [NVEC] = '{
    8'h01,  // R3/R7 0->1
    8'h45,  // R4 c0 taken 1->5
    8'h08,  // R3 5->8
    8'h8E,  // R6 c1 only 8->14
    8'hFF,  // R3 conds ignored, R7 14->63 no increment
    8'h00,  // R7 63->0
    8'h01,
    8'h84,  // R4 c1 ignored 1->4
    8'h89,  // R5 c1 taken 4->9
    8'h00,
    8'h01,
    8'h04,
    8'h48,  // R5 c0 ignored 4->8
    8'hCF,  // R6 both 8->15
    8'h3E,  // R7 15->62
    8'h42,  // R3 c0 ignored 62->2
    8'h03,
    8'h00,
    8'h01,
    8'h04,
    8'h08,
    8'h0C,  // R6 none 8->12
    8'h00,
    8'h01,
    8'h04,
    8'h08,
    8'h4D,  // R6 c0 only 8->13
    8'h00
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  condIn = 2'b00;
  logic [15:0] ctrlOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  usq_top u0 (
    .clk     (clk),
    .rst     (rst),
    .condIn  (condIn),
    .ctrlOut (ctrlOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R2: expected control field of word a
  function automatic logic [15:0] expCtrl(input logic [5:0] a);
    return {a ^ 6'h2A, 4'h5, a};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: ctrlOut=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", ctrlOut, expCtrl(6'd0));
    rst = 1'b0;
    // main walk: drive at negedge, result visible by the next negedge
    for (int i = 0; i < NVEC; i++) begin
      condIn = VEC[i][7:6];
      @(negedge clk);
      check($sformatf("R2 walk step %0d", i), ctrlOut, expCtrl(VEC[i][5:0]));
    end
    // R8: reset in the middle of a run overrides a pending branch
    condIn = 2'b00;
    @(negedge clk);
    check("R8 pre-step to 1", ctrlOut, expCtrl(6'd1));
    condIn = 2'b11;
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset beats branch", ctrlOut, expCtrl(6'd0));
    condIn = 2'b01;
    @(negedge clk);
    check("R8 reset held", ctrlOut, expCtrl(6'd0));
    condIn = 2'b10;
    @(negedge clk);
    check("R1 reset held again", ctrlOut, expCtrl(6'd0));
    rst = 1'b0;
    condIn = 2'b00;
    @(negedge clk);
    check("R1 restart from word 0", ctrlOut, expCtrl(6'd1));
    condIn = 2'b01;
    @(negedge clk);
    check("R4 after restart", ctrlOut, expCtrl(6'd5));
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 2000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

endmodule